// File: doc/BRIEF.md
# Sliding-Window Seed Sequencer

This block feeds seeds to a B-bit LFSR pattern generator from a single stored bit string. Rather than holding each seed as its own word, it keeps one n-bit sequence and treats every run of B adjacent bits as a seed. A one-bit left shift moves to the next window, so n stored bits give n-B+1 seeds. Each chosen seed loads the generator once, and one test results from that load.

A parallel per-window flag string, present when the `USE_FLAGS` parameter is set, picks the windows that actually drive a test. Windows whose flag is clear are passed over and the generator is not loaded for them. Both strings are written through a preload port while the block is idle. A start pulse walks the windows from first to last. For each selected window the block gives a one-cycle load strobe and then waits for the generator to report that its test is done. After the last window it raises a done flag and stays idle until the next start.

Top module: `seed_window_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `seed_load_o` are low and `win_idx_o` is 0.
- R2: `pre_bits` bit k holds sequence bit s_k. While window i is current, `seed_o` bit SEED_W-1 carries s_i and `seed_o` bit 0 carries s_(i+SEED_W-1). Each step shifts the window by exactly one bit.
- R3: One run visits exactly SEQ_LEN-SEED_W+1 windows, indices 0 to SEQ_LEN-SEED_W, and does not wrap. With `USE_FLAGS`=0 every window gives one load strobe.
- R4: `pre_flags` bit i belongs to window i. A window with flag 1 gets a load strobe. A window with flag 0 is skipped without one.
- R5: `seed_load_o` is high for exactly one cycle per selected window. The block then holds that window until `test_done_i` is seen. `test_done_i` has no effect at any other time.
- R6: `win_idx_o` is 0 in the cycle after start and rises by one on every shift.
- R7: When the last window has been handled, `done_o` goes high and `busy_o` goes low. `done_o` then stays high, with `win_idx_o` at the last index, until the next start.
- R8: A start that arrives while busy is ignored. The run in progress continues unchanged.
- R9: A preload that arrives while busy is ignored. The stored sequence and flags remain as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from window 0 (only while idle) |
| pre_load | input | 1 | Store `pre_bits` and `pre_flags` (only while idle) |
| pre_bits | input | SEQ_LEN | Seed sequence, bit k = s_k |
| pre_flags | input | SEQ_LEN-SEED_W+1 | Per-window apply flags, bit i = window i |
| test_done_i | input | 1 | Pattern generator finished the current test |
| seed_o | output | SEED_W | Current window, first sequence bit at MSB |
| seed_load_o | output | 1 | One-cycle strobe to load the LFSR with `seed_o` |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The last run finished |
| win_idx_o | output | IDX_W | Index of the current window |

## Verification
The hardest case to reach from the ports is a start and a preload that arrive while a run sits in the wait state. Both must leave the walk and the stored contents untouched. The bench drives both in the middle of a sparse-flag run, with a different bit string on the preload bus. It then checks that the same run ends with the expected load count. A second full run follows and must still present the original seeds. Skipped windows leave no trace on the strobe, so the bench works out from the flag string which window index each strobe must carry. It also uses a flag string of all zeros, which must finish with no strobe at all.

// File: rtl/seqwin_pkg.sv
package seqwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  // number of distinct non-wrapping windows in a sequence
  function automatic int win_count(input int seq_len, input int seed_w);
    return seq_len - seed_w + 1;
  endfunction

  // width needed to hold an index 0 .. wins-1 (at least one bit)
  function automatic int idx_width(input int wins);
    return (wins <= 2) ? 1 : $clog2(wins);
  endfunction

endpackage

// File: rtl/seed_shift_reg.sv
module seed_shift_reg #(
  parameter int SEQ_LEN = 12,
  parameter int SEED_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [SEQ_LEN-1:0] load_bits,
  input  logic               restart,
  input  logic               shift_en,
  output logic [SEED_W-1:0]  seed
);

  // internal order: bit SEQ_LEN-1 is the leftmost (first) sequence bit
  logic [SEQ_LEN-1:0] rev_bits;
  logic [SEQ_LEN-1:0] store_q;
  logic [SEQ_LEN-1:0] work_q;

  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_rev
    assign rev_bits[SEQ_LEN-1-k] = load_bits[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      work_q  <= '0;
    end else begin
      if (load_en) store_q <= rev_bits;
      if (restart) work_q <= load_en ? rev_bits : store_q;
      else if (shift_en) work_q <= {work_q[SEQ_LEN-2:0], 1'b0};
    end
  end

  assign seed = work_q[SEQ_LEN-1 -: SEED_W];

  if (SEED_W > 1) begin : g_chk
    // R2: after a shift the window has moved by exactly one bit
    a_r2_one_bit_slide: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> seed[SEED_W-1:1] == $past(seed[SEED_W-2:0]));
  end

endmodule

// File: rtl/flag_shift_reg.sv
module flag_shift_reg #(
  parameter int WINS      = 9,
  parameter bit USE_FLAGS = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [WINS-1:0] load_flags,
  input  logic            restart,
  input  logic            shift_en,
  output logic            cur_flag
);

  if (USE_FLAGS) begin : g_flags
    logic [WINS-1:0] store_q;
    logic [WINS-1:0] work_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= '0;
        work_q  <= '0;
      end else begin
        if (load_en) store_q <= load_flags;
        if (restart) work_q <= load_en ? load_flags : store_q;
        else if (shift_en) work_q <= {1'b0, work_q[WINS-1:1]};
      end
    end

    assign cur_flag = work_q[0];

    if (WINS > 1) begin : g_chk
      // R4: flag string moves in lockstep with the seed window
      a_r4_flag_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !restart) |=> cur_flag == $past(work_q[1]));
    end
  end else begin : g_all
    logic unused_flag_inputs;
    assign unused_flag_inputs = ^{clk, rst_n, load_en, load_flags, restart, shift_en};
    assign cur_flag = 1'b1;
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seqwin_pkg::*;
#(
  parameter int WINS  = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pre_load,
  input  logic             test_done,
  input  logic             cur_flag,
  output logic             seed_load,
  output logic             shift_en,
  output logic             restart,
  output logic             load_en,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINS - 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             idle, is_last, advance, finish;

  assign idle      = (state_q == ST_IDLE);
  assign restart   = idle && start;
  assign load_en   = idle && pre_load;
  assign is_last   = (idx_q == LAST_IDX);
  assign seed_load = (state_q == ST_EVAL) && cur_flag;
  assign advance   = ((state_q == ST_EVAL) && !cur_flag) ||
                     ((state_q == ST_WAIT) && test_done);
  assign shift_en  = advance && !is_last;
  assign finish    = advance && is_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_EVAL;
      ST_EVAL: begin
        if (cur_flag)    state_d = ST_WAIT;
        else if (finish) state_d = ST_IDLE;
      end
      ST_WAIT: if (test_done) state_d = finish ? ST_IDLE : ST_EVAL;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (restart)       idx_q <= '0;
      else if (shift_en) idx_q <= idx_q + IDX_W'(1);
      if (restart)       done_q <= 1'b0;
      else if (finish)   done_q <= 1'b1;
    end
  end

  assign busy = !idle;
  assign done = done_q;
  assign idx  = idx_q;

  // R5: the load strobe never lasts longer than one cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !seed_load);
  // R5: without test_done the block stays on the current window
  a_r5_hold_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !test_done) |=> (state_q == ST_WAIT && $stable(idx_q)));
  // R6: each shift moves the index up by one
  a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> idx_q == $past(idx_q) + IDX_W'(1));
  // R3: the index never passes the last window
  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  // R7: done and busy are never high together
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
  // R8: a start while busy does not reset the walk
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !advance) |=> $stable(idx_q));

endmodule

// File: rtl/seed_window_seq.sv
module seed_window_seq
  import seqwin_pkg::*;
#(
  parameter int SEQ_LEN   = 12,
  parameter int SEED_W    = 4,
  parameter bit USE_FLAGS = 1'b1,
  localparam int WINS     = win_count(SEQ_LEN, SEED_W),
  localparam int IDX_W    = idx_width(WINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pre_load,
  input  logic [SEQ_LEN-1:0] pre_bits,
  input  logic [WINS-1:0]    pre_flags,
  input  logic               test_done_i,
  output logic [SEED_W-1:0]  seed_o,
  output logic               seed_load_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   win_idx_o
);

  logic cur_flag, shift_en, restart, load_en;

  seq_ctrl #(.WINS(WINS), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pre_load  (pre_load),
    .test_done (test_done_i),
    .cur_flag  (cur_flag),
    .seed_load (seed_load_o),
    .shift_en  (shift_en),
    .restart   (restart),
    .load_en   (load_en),
    .busy      (busy_o),
    .done      (done_o),
    .idx       (win_idx_o)
  );

  seed_shift_reg #(.SEQ_LEN(SEQ_LEN), .SEED_W(SEED_W)) u_seed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_bits (pre_bits),
    .restart   (restart),
    .shift_en  (shift_en),
    .seed      (seed_o)
  );

  flag_shift_reg #(.WINS(WINS), .USE_FLAGS(USE_FLAGS)) u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_flags (pre_flags),
    .restart    (restart),
    .shift_en   (shift_en),
    .cur_flag   (cur_flag)
  );

  // R9: stored contents only change while idle
  a_r9_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !busy_o);

endmodule

// File: tb/seed_window_seq_bench.sv
module seed_window_seq_bench;

  localparam int N = 12;
  localparam int B = 4;
  localparam int W = N - B + 1;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pre_load = 1'b0, test_done = 1'b0, sel = 1'b0;
  logic [N-1:0] pre_bits = '0;
  logic [W-1:0] pre_flags = '0;

  logic [B-1:0]  seed1, seed2, m_seed;
  logic          ld1, ld2, m_load, bz1, bz2, m_busy, dn1, dn2, m_done;
  logic [IW-1:0] ix1, ix2, m_idx;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seed_window_seq #(.SEQ_LEN(N), .SEED_W(B), .USE_FLAGS(1'b1)) u_seed_window_seq (
    .clk(clk), .rst_n(rst_n), .start(start && !sel), .pre_load(pre_load),
    .pre_bits(pre_bits), .pre_flags(pre_flags), .test_done_i(test_done),
    .seed_o(seed1), .seed_load_o(ld1), .busy_o(bz1), .done_o(dn1), .win_idx_o(ix1));

  seed_window_seq #(.SEQ_LEN(N), .SEED_W(B), .USE_FLAGS(1'b0)) u_noflag (
    .clk(clk), .rst_n(rst_n), .start(start && sel), .pre_load(pre_load),
    .pre_bits(pre_bits), .pre_flags(pre_flags), .test_done_i(test_done),
    .seed_o(seed2), .seed_load_o(ld2), .busy_o(bz2), .done_o(dn2), .win_idx_o(ix2));

  assign m_seed = sel ? seed2 : seed1;
  assign m_load = sel ? ld2 : ld1;
  assign m_busy = sel ? bz2 : bz1;
  assign m_done = sel ? dn2 : dn1;
  assign m_idx  = sel ? ix2 : ix1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [B-1:0] exp_seed(input logic [N-1:0] sv, input int w);
    logic [B-1:0] r;
    for (int b = 0; b < B; b++) r[B-1-b] = sv[w+b];
    return r;
  endfunction

  task automatic preload(input logic [N-1:0] sv, input logic [W-1:0] fl);
    @(negedge clk);
    pre_bits = sv; pre_flags = fl; pre_load = 1'b1;
    @(negedge clk);
    pre_load = 1'b0;
  endtask

  // walks one run, answering each strobe after 'delay' idle cycles
  task automatic run_seq(input logic s, input logic [W-1:0] fl, input logic [N-1:0] sv,
                         input int delay, input bit inject, input string tag);
    int nxt = 0;
    int loads = 0;
    int expl = 0;
    bit seen_done = 0;
    for (int i = 0; i < W; i++) if (fl[i]) expl++;
    sel = s;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(m_idx == 0 && m_busy && !m_done, {tag, " R6 index zero after start"}, int'(m_idx), 0);
    for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        test_done = 1'b0; start = 1'b0; pre_load = 1'b0;
      end
      if (m_done) begin
        seen_done = 1;
      end else if (m_load) begin
        while (nxt < W && !fl[nxt]) nxt++;
        chk(int'(m_idx) == nxt, {tag, " R4 strobe on flagged window"}, int'(m_idx), nxt);
        chk(m_seed == exp_seed(sv, nxt), {tag, " R2 seed bits of window"},
            int'(m_seed), int'(exp_seed(sv, nxt)));
        nxt++;
        loads++;
        for (int d = 0; d < delay; d++) begin
          @(negedge clk);
          start = 1'b0; pre_load = 1'b0;
          chk(!m_load && int'(m_idx) == nxt - 1, {tag, " R5 hold while waiting"},
              int'(m_idx), nxt - 1);
          if (inject && loads == 1 && d == 0) begin
            start = 1'b1; pre_load = 1'b1; pre_bits = ~sv; pre_flags = '1;
          end
        end
        test_done = 1'b1;
      end
    end
    test_done = 1'b0; start = 1'b0; pre_load = 1'b0;
    chk(loads == expl, {tag, " R3 number of strobes"}, loads, expl);
    chk(m_done && !m_busy, {tag, " R7 done raised"}, int'(m_done), 1);
    chk(int'(m_idx) == W - 1, {tag, " R3 last index reached"}, int'(m_idx), W - 1);
  endtask

  task automatic t_reset;
    chk(!bz1 && !dn1 && !ld1, "R1 reset outputs low", int'({bz1, dn1, ld1}), 0);
    chk(ix1 == 0, "R1 reset index", int'(ix1), 0);
  endtask

  task automatic t_done_holds;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      test_done = (k == 2);
      chk(dn1 && !bz1 && !ld1 && int'(ix1) == W - 1, "R7 done persists", int'(dn1), 1);
    end
    test_done = 1'b0;
  endtask

  task automatic t_idle_done_ignored;
    @(negedge clk);
    test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
    chk(!bz1 && !ld1, "R5 test_done while idle ignored", int'(bz1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    preload(12'hB2D, '1);
    run_seq(1'b0, '1, 12'hB2D, 1, 0, "all-flags");
    t_done_holds();
    t_idle_done_ignored();
    preload(12'h5C3, 9'b100000011);
    run_seq(1'b0, 9'b100000011, 12'h5C3, 3, 0, "sparse");
    preload(12'h9E1, '0);
    run_seq(1'b0, '0, 12'h9E1, 1, 0, "no-flags-set");
    preload(12'h3A6, 9'b000010101);
    run_seq(1'b0, 9'b000010101, 12'h3A6, 4, 1, "R8 R9 busy-inject");
    run_seq(1'b0, 9'b000010101, 12'h3A6, 1, 0, "R9 store kept");
    preload(12'hD47, '0);
    run_seq(1'b1, '1, 12'hD47, 2, 0, "R3 flags-off");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule